// File: doc/BRIEF.md
# Asynchronous SRAM Controller with Byte Lanes

This block connects a synchronous requester to an external asynchronous SRAM with a 16-bit data path and an 18-bit word address. A requester presents one request at a time, either a read or a write. Each request carries an address, write data and a two-bit lane mask. The controller then runs the memory pins through a fixed sequence of phases. It produces active-low chip select, write strobe, output enable and one strobe per byte lane. It drives the shared data bus only while a write is in progress. A read ends with its data and a one-cycle valid pulse, and a write ends with a one-cycle done pulse.

Every phase length is counted in clock cycles and derived from the memory's timing minima and the clock period, all of them parameters. Each minimum is rounded up to whole cycles. At the default 4 ns clock this gives one address-setup cycle, a three-cycle write strobe and a three-cycle read wait. All memory pins come straight from flops, so the strobes cannot glitch.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, chip select, write strobe, output enable and both lane strobes are high, `ready` is high, and `rdValid` and `wrDone` are low.
- R2: A request is taken only on a clock edge where `reqValid` and `ready` are both high. `ready` is low from the cycle after acceptance until the operation finishes. A request presented while `ready` is low has no effect on the memory.
- R3: In a write, the write strobe stays low for at least ceil-above (8 ns / clock period) cycles, which is the smallest count longer than 8 ns (3 cycles at 4 ns).
- R4: In a write, the address is stable for at least one cycle before the write strobe falls. It does not change while the strobe is low, or in the cycle after the strobe rises.
- R5: Write data on the bus is stable for at least ceil(5 ns / clock period) cycles (2 at 4 ns) before the write strobe rises.
- R6: `reqByteEn` bit 1 selects data bits 15:8 through the upper strobe, and bit 0 selects bits 7:0 through the lower strobe. A lane strobe is low only while chip select is low and that lane is enabled. Only enabled lanes of a write change the memory.
- R7: Output enable stays high whenever the write strobe is low. The controller drives the data bus only while output enable is high.
- R8: A read samples the bus no earlier than ceil(10 ns / clock period) cycles after the address settles. With the defaults, `rdValid` is high for exactly one cycle, 5 cycles after the accepting edge, and carries the addressed word.
- R9: In a read, a disabled lane keeps its strobe high and returns zero in `rdData`.
- R10: With the defaults, a write raises `wrDone` for exactly one cycle, 6 cycles after the accepting edge, in the same cycle that `ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqByteEn | input | 2 | Lane mask, bit 1 = bits 15:8, bit 0 = bits 7:0 |
| ready | output | 1 | Idle, able to accept a request |
| rdValid | output | 1 | One-cycle read completion |
| rdData | output | 16 | Read data, disabled lanes zero |
| wrDone | output | 1 | One-cycle write completion |
| memAddr | output | 18 | Memory address pins |
| memData | inout | 16 | Shared memory data bus |
| memCeN | output | 1 | Chip select, active low |
| memWeN | output | 1 | Write strobe, active low |
| memOeN | output | 1 | Output enable, active low |
| memUbN | output | 1 | Upper lane strobe, active low |
| memLbN | output | 1 | Lower lane strobe, active low |

## Verification
The hardest case to produce is a request that arrives while the controller is busy, because a well-behaved requester never offers one. The stimulus does this on purpose: it holds a second write to a different address on the request port during the write-strobe window. It then reads that second address back to show the memory never saw it.

Early sampling is only visible if the memory model returns wrong data before the access time has elapsed. For that reason the model drives the inverted word until enough cycles have passed since the address last changed. Random traffic over a small pool of addresses gives back-to-back read-after-write and lane-merge cases.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int DATA_W = LANE_W * LANES;

  // Strobes from the sequencer to the datapath, one set per cycle.
  typedef struct packed {
    logic loadReq;   // latch the request fields
    logic selChip;   // chip select asserted
    logic weLow;     // write strobe asserted
    logic oeLow;     // output enable asserted
    logic busDrive;  // controller owns the data bus
    logic capture;   // sample the bus into the read register
    logic doneWr;    // write finishes this cycle
  } ctlStrobe_t;

  // Whole cycles covering at least psVal.
  function automatic int ceilCyc(int psVal, int clkPs);
    return (psVal + clkPs - 1) / clkPs;
  endfunction

  // Smallest whole cycle count strictly longer than psVal.
  function automatic int aboveCyc(int psVal, int clkPs);
    return psVal / clkPs + 1;
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int ASU_CYC = 1,
  parameter int WE_CYC  = 3,
  parameter int RD_CYC  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       ready,
  output ctlStrobe_t strb
);

  localparam int MAX_CYC = maxOf(maxOf(ASU_CYC, WE_CYC), RD_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] ASU_LAST = CNT_W'(ASU_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LAST  = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE,
    S_WSETUP,
    S_WPULSE,
    S_WHOLD,
    S_RWAIT,
    S_RCAPT
  } seqState_t;

  seqState_t             state, stateNxt;
  logic [CNT_W-1:0]      phaseCnt, phaseCntNxt;

  always_comb begin
    stateNxt    = state;
    phaseCntNxt = phaseCnt;
    strb        = '0;
    ready       = 1'b0;
    unique case (state)
      S_IDLE: begin
        ready = 1'b1;
        if (reqValid) begin
          strb.loadReq = 1'b1;
          phaseCntNxt  = '0;
          stateNxt     = reqWrite ? S_WSETUP : S_RWAIT;
        end
      end
      S_WSETUP: begin
        strb.selChip  = 1'b1;
        strb.busDrive = 1'b1;
        if (phaseCnt == ASU_LAST) begin
          phaseCntNxt = '0;
          stateNxt    = S_WPULSE;
        end else begin
          phaseCntNxt = phaseCnt + 1'b1;
        end
      end
      S_WPULSE: begin
        strb.selChip  = 1'b1;
        strb.weLow    = 1'b1;
        strb.busDrive = 1'b1;
        if (phaseCnt == WE_LAST) begin
          phaseCntNxt = '0;
          stateNxt    = S_WHOLD;
        end else begin
          phaseCntNxt = phaseCnt + 1'b1;
        end
      end
      S_WHOLD: begin
        strb.selChip  = 1'b1;
        strb.busDrive = 1'b1;
        strb.doneWr   = 1'b1;
        stateNxt      = S_IDLE;
      end
      S_RWAIT: begin
        strb.selChip = 1'b1;
        strb.oeLow   = 1'b1;
        if (phaseCnt == RD_LAST) begin
          phaseCntNxt = '0;
          stateNxt    = S_RCAPT;
        end else begin
          phaseCntNxt = phaseCnt + 1'b1;
        end
      end
      S_RCAPT: begin
        strb.selChip = 1'b1;
        strb.oeLow   = 1'b1;
        strb.capture = 1'b1;
        stateNxt     = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      phaseCnt <= '0;
    end else begin
      state    <= stateNxt;
      phaseCnt <= phaseCntNxt;
    end
  end

endmodule

// File: rtl/sram_ctl_path.sv
`timescale 1ns/1ps
module sram_ctl_path
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqByteEn,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memData,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [LANES-1:0]  laneN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              wrDone,
  output logic              busDriveEn
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  laneEnQ;
  logic [LANES-1:0]  laneStrbNxt;
  logic [DATA_W-1:0] capWord;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    // Each lane is released unless a write owns the bus.
    assign memData[l*LANE_W +: LANE_W] =
      busDriveEn ? wdataQ[l*LANE_W +: LANE_W] : {LANE_W{1'bz}};
    // Disabled lanes are not driven by the memory: return zero.
    assign capWord[l*LANE_W +: LANE_W] =
      laneEnQ[l] ? memData[l*LANE_W +: LANE_W] : {LANE_W{1'b0}};
    assign laneStrbNxt[l] = !(strb.selChip && laneEnQ[l]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      laneEnQ <= '0;
    end else if (strb.loadReq) begin
      addrQ   <= reqAddr;
      wdataQ  <= reqWdata;
      laneEnQ <= reqByteEn;
    end
  end

  // Pin flops: all memory controls leave from registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCeN     <= 1'b1;
      memWeN     <= 1'b1;
      memOeN     <= 1'b1;
      laneN      <= '1;
      busDriveEn <= 1'b0;
    end else begin
      memCeN     <= !strb.selChip;
      memWeN     <= !strb.weLow;
      memOeN     <= !strb.oeLow;
      laneN      <= laneStrbNxt;
      busDriveEn <= strb.busDrive;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      wrDone  <= 1'b0;
    end else begin
      rdValid <= strb.capture;
      wrDone  <= strb.doneWr;
      if (strb.capture) rdData <= capWord;
    end
  end

  assign memAddr = addrQ;

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int CLK_PS     = 4000,
  parameter int T_ACC_PS   = 10000,
  parameter int T_WE_PS    = 8000,
  parameter int T_DSU_PS   = 5000,
  parameter int T_ASU_PS   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  input  logic [1:0]        reqByteEn,
  output logic              ready,
  output logic              rdValid,
  output logic [15:0]       rdData,
  output logic              wrDone,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [15:0]       memData,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memUbN,
  output logic              memLbN
);

  localparam int ASU_CYC = maxOf(1, ceilCyc(T_ASU_PS, CLK_PS));
  localparam int WE_CYC  = maxOf(aboveCyc(T_WE_PS, CLK_PS), ceilCyc(T_DSU_PS, CLK_PS));
  localparam int RD_CYC  = maxOf(1, ceilCyc(T_ACC_PS, CLK_PS));

  ctlStrobe_t       strb;
  logic [LANES-1:0] laneN;
  logic             busDriveEn;

  sram_ctl_seq #(
    .ASU_CYC(ASU_CYC),
    .WE_CYC (WE_CYC),
    .RD_CYC (RD_CYC)
  ) i_seq (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .ready   (ready),
    .strb    (strb)
  );

  sram_ctl_path #(
    .ADDR_W(ADDR_W)
  ) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .reqByteEn (reqByteEn),
    .memAddr   (memAddr),
    .memData   (memData),
    .memCeN    (memCeN),
    .memWeN    (memWeN),
    .memOeN    (memOeN),
    .laneN     (laneN),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .wrDone    (wrDone),
    .busDriveEn(busDriveEn)
  );

  assign memUbN = laneN[1];
  assign memLbN = laneN[0];

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int WE_CYC = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              ready,
  input logic              rdValid,
  input logic              wrDone,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic              memUbN,
  input logic              memLbN,
  input logic              busDriveEn,
  input logic [ADDR_W-1:0] memAddr
);

  localparam int CW = $clog2(WE_CYC + 2) + 1;
  logic [CW-1:0] weLowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                weLowCnt <= '0;
    else if (!memWeN) begin
      if (weLowCnt != '1)     weLowCnt <= weLowCnt + 1'b1;
    end else                  weLowCnt <= '0;
  end

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt >= CW'(WE_CYC))); // R3
  AST_ADDR_FIXED_WE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> $stable(memAddr)); // R4
  AST_ADDR_HOLD_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> $stable(memAddr)); // R4
  AST_OE_OFF_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN); // R7
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    busDriveEn |-> memOeN); // R7
  AST_LANE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    (!memUbN || !memLbN) |-> !memCeN); // R6
  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN); // R6
  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ready) |=> !ready); // R2
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R8
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrDone |=> !wrDone); // R10
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rstN)
    wrDone |-> ready); // R10

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .WE_CYC(WE_CYC)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .ready     (ready),
  .rdValid   (rdValid),
  .wrDone    (wrDone),
  .memCeN    (memCeN),
  .memWeN    (memWeN),
  .memOeN    (memOeN),
  .memUbN    (memUbN),
  .memLbN    (memLbN),
  .busDriveEn(busDriveEn),
  .memAddr   (memAddr)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

  localparam int AW      = 18;
  localparam int ACC_CYC = 3;              // ceil(10 ns / 4 ns)
  localparam int WE_MIN  = 3;              // smallest count above 8 ns
  localparam int DSU_CYC = 2;              // ceil(5 ns / 4 ns)
  localparam int ASU_CYC = 1;
  localparam int RD_LAT  = ACC_CYC + 2;    // negedges from accept to rdValid
  localparam int WR_LAT  = ASU_CYC + WE_MIN + 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [15:0]   reqWdata = '0;
  logic [1:0]    reqByteEn = '0;
  logic          ready, rdValid, wrDone;
  logic [15:0]   rdData;
  logic [AW-1:0] memAddr;
  wire  [15:0]   memData;
  logic          memCeN, memWeN, memOeN, memUbN, memLbN;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  sram_async_ctrl #(
    .ADDR_W(AW), .CLK_PS(4000), .T_ACC_PS(10000),
    .T_WE_PS(8000), .T_DSU_PS(5000), .T_ASU_PS(0)
  ) i_sram_async_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqByteEn(reqByteEn),
    .ready(ready), .rdValid(rdValid), .rdData(rdData), .wrDone(wrDone),
    .memAddr(memAddr), .memData(memData), .memCeN(memCeN), .memWeN(memWeN),
    .memOeN(memOeN), .memUbN(memUbN), .memLbN(memLbN)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- memory contents and expectation ----------------
  logic [15:0] mdlMem [logic [AW-1:0]];
  logic [15:0] expMem [logic [AW-1:0]];

  function automatic logic [15:0] initWord(logic [AW-1:0] a);
    return 16'(a[15:0] * 16'h9E37) ^ {14'h0, a[17:16]} ^ 16'h5A0F;
  endfunction
  function automatic logic [15:0] mdlGet(logic [AW-1:0] a);
    return mdlMem.exists(a) ? mdlMem[a] : initWord(a);
  endfunction
  function automatic logic [15:0] expGet(logic [AW-1:0] a);
    return expMem.exists(a) ? expMem[a] : initWord(a);
  endfunction
  function automatic logic [15:0] mergeLanes(logic [15:0] oldW, logic [15:0] newW, logic [1:0] be);
    return {be[1] ? newW[15:8] : oldW[15:8], be[0] ? newW[7:0] : oldW[7:0]};
  endfunction
  function automatic logic [15:0] maskLanes(logic [15:0] w, logic [1:0] be);
    return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
  endfunction

  // ---------------- asynchronous memory model (negedge sampled) ----------------
  logic [15:0]   mdlWord = '0;
  logic          drvHi = 1'b0, drvLo = 1'b0;
  logic [AW-1:0] prevAddr, weAddr;
  logic [15:0]   prevData;
  logic          prevWeN = 1'b1;
  int            addrCnt = 0, cntHi = 0, cntLo = 0, weLowCnt = 0;

  assign memData[15:8] = drvHi ? mdlWord[15:8] : 8'bz;
  assign memData[7:0]  = drvLo ? mdlWord[7:0]  : 8'bz;

  always @(negedge clk) begin
    if (!rstN) begin
      prevAddr = memAddr; prevData = memData; prevWeN = 1'b1;
      addrCnt = 0; cntHi = 0; cntLo = 0; weLowCnt = 0;
      drvHi = 1'b0; drvLo = 1'b0;
    end else begin
      if (memAddr !== prevAddr) begin addrCnt = 0; prevAddr = memAddr; end
      else addrCnt++;
      if (memData[15:8] !== prevData[15:8]) cntHi = 0; else cntHi++;
      if (memData[7:0]  !== prevData[7:0])  cntLo = 0; else cntLo++;
      prevData = memData;
      if (prevWeN && !memWeN) begin
        weLowCnt = 1; weAddr = memAddr;
        chk(addrCnt >= 1, "R4", "address setup before write strobe", addrCnt, 1);
      end else if (!memWeN) begin
        weLowCnt++;
        chk(memAddr == weAddr, "R4", "address moved under write strobe", 32'(memAddr), 32'(weAddr));
      end
      if (!memWeN) chk(memOeN == 1'b1, "R7", "output enable during write strobe", memOeN, 1);
      if (!prevWeN && memWeN) begin
        chk(weLowCnt >= WE_MIN, "R3", "write strobe width", weLowCnt, WE_MIN);
        chk(memAddr == weAddr, "R4", "address hold after strobe rise", 32'(memAddr), 32'(weAddr));
        if (!memCeN) begin
          logic [15:0] w;
          w = mdlGet(memAddr);
          if (!memUbN) begin
            chk(cntHi >= DSU_CYC, "R5", "upper data setup", cntHi, DSU_CYC);
            w[15:8] = memData[15:8];
          end
          if (!memLbN) begin
            chk(cntLo >= DSU_CYC, "R5", "lower data setup", cntLo, DSU_CYC);
            w[7:0] = memData[7:0];
          end
          mdlMem[memAddr] = w;
        end
      end
      prevWeN = memWeN;
      drvHi = !memCeN && memWeN && !memOeN && !memUbN;
      drvLo = !memCeN && memWeN && !memOeN && !memLbN;
      mdlWord = (addrCnt >= ACC_CYC) ? mdlGet(memAddr) : ~mdlGet(memAddr);
    end
  end

  // ---------------- request tasks ----------------
  task automatic doWrite(logic [AW-1:0] a, logic [15:0] d, logic [1:0] be);
    int n;
    while (!ready) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d; reqByteEn = be;
    @(negedge clk);
    reqValid = 1'b0;
    n = 1;
    chk(!ready, "R2", "ready low while writing", ready, 0);
    while (!wrDone && n < 40) begin @(negedge clk); n++; end
    chk(n == WR_LAT, "R10", "write done latency", n, WR_LAT);
    chk(ready, "R10", "ready with write done", ready, 1);
    chk(!memCeN && memUbN == !be[1] && memLbN == !be[0], "R6", "lane strobes in write",
        {memCeN, memUbN, memLbN}, {1'b0, !be[1], !be[0]});
    expMem[a] = mergeLanes(expGet(a), d, be);
    @(negedge clk);
    chk(!wrDone, "R10", "write done one cycle", wrDone, 0);
  endtask

  task automatic doRead(logic [AW-1:0] a, logic [1:0] be);
    int n;
    logic [15:0] expW;
    while (!ready) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a; reqWdata = 16'hDEAD; reqByteEn = be;
    @(negedge clk);
    reqValid = 1'b0;
    n = 1;
    while (!rdValid && n < 40) begin @(negedge clk); n++; end
    chk(n == RD_LAT, "R8", "read valid latency", n, RD_LAT);
    expW = maskLanes(expGet(a), be);
    if (be == 2'b11) chk(rdData == expW, "R8", "read data", rdData, expW);
    else             chk(rdData == expW, "R9", "masked read data", rdData, expW);
    chk(memUbN == !be[1] && memLbN == !be[0] && !memOeN, "R9", "lane strobes in read",
        {memOeN, memUbN, memLbN}, {1'b0, !be[1], !be[0]});
    @(negedge clk);
    chk(!rdValid, "R8", "read valid one cycle", rdValid, 0);
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      chk(1'b0, "WD", "watchdog expired", 0, 1);
      finishRun();
    end
  end

  initial begin
    logic [AW-1:0] pool [16];
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 16; i++) pool[i] = AW'($urandom);
    pool[0] = '0;
    pool[1] = '1;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk({memCeN, memWeN, memOeN, memUbN, memLbN} == 5'b11111, "R1", "pins idle in reset",
        {memCeN, memWeN, memOeN, memUbN, memLbN}, 5'b11111);
    rstN = 1'b1;
    @(negedge clk);
    chk(ready && !rdValid && !wrDone, "R1", "status after reset", {ready, rdValid, wrDone}, 3'b100);
    chk({memCeN, memWeN, memOeN, memUbN, memLbN} == 5'b11111, "R1", "pins idle after reset",
        {memCeN, memWeN, memOeN, memUbN, memLbN}, 5'b11111);

    // R8 unwritten word, then full write and read-back
    doRead(pool[2], 2'b11);
    doWrite(pool[2], 16'hA1B2, 2'b11);
    doRead(pool[2], 2'b11);
    doWrite(pool[0], 16'h1234, 2'b11);
    doWrite(pool[1], 16'hFEDC, 2'b11);
    doRead(pool[0], 2'b11);
    doRead(pool[1], 2'b11);

    // R6 lane writes, R9 lane reads
    doWrite(pool[3], 16'h0000, 2'b11);
    doWrite(pool[3], 16'hC3FF, 2'b10);
    doRead(pool[3], 2'b11);
    doWrite(pool[3], 16'hFF5A, 2'b01);
    doRead(pool[3], 2'b11);
    doWrite(pool[3], 16'h9999, 2'b00);
    doRead(pool[3], 2'b11);
    doRead(pool[3], 2'b01);
    doRead(pool[3], 2'b10);
    doRead(pool[3], 2'b00);

    // R2 request offered while busy must be ignored
    begin
      while (!ready) @(negedge clk);
      reqValid = 1'b1; reqWrite = 1'b1; reqAddr = pool[4]; reqWdata = 16'h7777; reqByteEn = 2'b11;
      @(negedge clk);
      reqAddr = pool[5]; reqWdata = 16'h4242; reqByteEn = 2'b11;
      repeat (2) @(negedge clk);
      chk(!ready, "R2", "busy during offered request", ready, 0);
      reqValid = 1'b0;
      while (!wrDone) @(negedge clk);
      expMem[pool[4]] = 16'h7777;
      @(negedge clk);
      doRead(pool[5], 2'b11);
      doRead(pool[4], 2'b11);
    end

    // random traffic
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      logic [1:0]    be;
      a  = pool[$urandom_range(0, 15)];
      be = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 0) doWrite(a, 16'($urandom), be);
      else                           doRead(a, be);
    end
    finishRun();
  end

endmodule